// File: doc/BRIEF.md
# Return Stack with Carry Save

This block is the return-address stack of a small 4-bit processor core. On a subroutine call or on interrupt entry it saves a 12-bit entry: the carry flag in the top bit and the low 11 program-counter bits below it. The page bit above those 11 bits is kept elsewhere and is never saved. On a return it presents the most recently saved entry and pops it. A select input tells the core whether the carry flag is to be reloaded from the entry. The interrupt return reloads the carry. The value-returning return leaves the carry alone.

Calls and interrupts share four levels. A push into a full stack does not raise an error. It moves every entry down one place, and the oldest entry falls off the bottom and is lost. The saved address is computed inside the block. For a call it is the current address plus one, wrapping within the 11-bit field. For an interrupt entry it is the current address, which is the pre-empted instruction. The top entry is always visible at the outputs. During a pop cycle the outputs therefore carry the value being returned.

The reset input is asynchronous and active low. Its release is synchronized to the clock in two stages, so the block leaves reset two rising edges after `rst_n` goes high.

Top module: `ret_stack`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation, the occupancy is 0, `ret_pc_o` is 0, `ret_cy_o` is 0 and `cy_restore_o` is 0.
- R2: A push stores one entry, which then appears at the outputs one cycle later. The entry holds the carry input in its MSB (`ret_cy_o`) and an address in its low 11 bits (`ret_pc_o`). The address is `pc_i + 1` when `push_irq_i = 0` (call) and `pc_i` when `push_irq_i = 1` (interrupt entry).
- R3: Entries come back in last-in, first-out order. Each pop moves the next older entry to the outputs.
- R4: A push while 4 entries are held discards the oldest entry, and the occupancy stays at 4.
- R5: In a cycle with `pop_i = 1` and `push_i = 0`, `cy_restore_o` equals `ret_irq_i`, where 1 selects the interrupt return and 0 the value-returning return. In all other cycles `cy_restore_o` is 0.
- R6: A pop at occupancy 0 keeps the occupancy at 0 and presents the value in the bottom slot. That value is the oldest surviving entry left there by the pops that emptied the stack, or 0 after reset. The value stays unchanged across the empty pop.
- R7: When `push_i` and `pop_i` are both 1 in the same cycle, only the push takes effect and `cy_restore_o` is 0.
- R8: `depth_o` counts up by one on a push below 4 and down by one on a pop above 0, and holds otherwise.
- R9: A call from address 0x7FF saves 0x000. The increment wraps within 11 bits and never carries into the page bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Save an entry this cycle |
| push_irq_i | input | 1 | 1: interrupt entry (save pc_i); 0: call (save pc_i + 1) |
| pop_i | input | 1 | Remove the top entry this cycle |
| ret_irq_i | input | 1 | 1: interrupt return (restore carry); 0: value-returning return |
| pc_i | input | 11 | Current low program-counter bits |
| cy_i | input | 1 | Current carry flag |
| ret_pc_o | output | 11 | Address of the top entry |
| ret_cy_o | output | 1 | Carry of the top entry |
| cy_restore_o | output | 1 | Carry should be reloaded in this pop cycle |
| depth_o | output | 3 | Number of valid entries, 0 to 4 |

## Verification
The bench drives two overflowing pushes and then drains the stack. A design that dropped the newest entry instead of the oldest would return the wrong sequence, and a counter that wrapped past 4 would report a wrong occupancy. A call from 0x7FF checks that the increment does not spill into a twelfth bit. A simultaneous push and pop checks that the pop is ignored, since an extra pop would show up as a shortened drain later. Pops at zero occupancy, right after reset and after a drain, check that the count does not underflow and that the bottom slot value is presented and kept. The carry-restore flag is checked for both return kinds and for non-pop cycles. A reset asserted while entries are held must clear the occupancy and the entries at once.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned RSTK_DEPTH = 4;
  localparam int unsigned RSTK_PC_W  = 11;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rstk_op_e;
endpackage

// File: rtl/rstk_op_decode.sv
module rstk_op_decode
  import rstk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_l,
  input  logic     push_i,
  input  logic     pop_i,
  input  logic     ret_irq_i,
  output rstk_op_e op_o,
  output logic     cy_restore_o
);
  always_comb begin
    if (push_i)     op_o = OP_PUSH;
    else if (pop_i) op_o = OP_POP;
    else            op_o = OP_IDLE;
  end

  assign cy_restore_o = (op_o == OP_POP) && ret_irq_i;

  // R7: a push in the same cycle as a pop wins, and the carry is not restored
  p_push_wins_r7: assert property (@(posedge clk) disable iff (!rst_l)
    (push_i && pop_i) |-> (op_o == OP_PUSH) && !cy_restore_o);

  // R5: the restore flag only shows up in a pop cycle
  p_restore_pop_r5: assert property (@(posedge clk) disable iff (!rst_l)
    cy_restore_o |-> (pop_i && !push_i && ret_irq_i));
endmodule

// File: rtl/rstk_entry_fmt.sv
module rstk_entry_fmt #(
  parameter int unsigned PC_W = 11,
  localparam int unsigned ENT_W = PC_W + 1
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic             cy_i,
  input  logic             push_irq_i,
  output logic [ENT_W-1:0] entry_o
);
  logic [PC_W-1:0] pc_next;
  logic [PC_W-1:0] pc_save;

  // the increment wraps inside the field and never reaches the page bit
  assign pc_next = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
  assign pc_save = push_irq_i ? pc_i : pc_next;
  assign entry_o = {cy_i, pc_save};
endmodule

// File: rtl/rstk_depth.sv
module rstk_depth
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_l,
  input  rstk_op_e         op_i,
  output logic [CNT_W-1:0] depth_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] depth_d;
  logic             depth_en;

  always_comb begin
    depth_d  = depth_q;
    depth_en = 1'b0;
    case (op_i)
      OP_PUSH: if (depth_q != FULL) begin
        depth_d  = depth_q + 1'b1;
        depth_en = 1'b1;
      end
      OP_POP: if (depth_q != '0) begin
        depth_d  = depth_q - 1'b1;
        depth_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)        depth_q <= '0;
    else if (depth_en) depth_q <= depth_d;
  end

  assign depth_o = depth_q;

  // R4: the count saturates at the number of levels
  p_depth_cap_r4: assert property (@(posedge clk) disable iff (!rst_l)
    depth_q <= FULL);

  // R4: a push at full keeps the count at full
  p_full_push_r4: assert property (@(posedge clk) disable iff (!rst_l)
    (op_i == OP_PUSH && depth_q == FULL) |=> depth_q == FULL);

  // R8: a push below full adds one
  p_depth_up_r8: assert property (@(posedge clk) disable iff (!rst_l)
    (op_i == OP_PUSH && depth_q != FULL) |=> depth_q == $past(depth_q) + 1'b1);

  // R8: a pop above empty removes one
  p_depth_down_r8: assert property (@(posedge clk) disable iff (!rst_l)
    (op_i == OP_POP && depth_q != '0) |=> depth_q == $past(depth_q) - 1'b1);

  // R6: a pop at empty does not underflow
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (op_i == OP_POP && depth_q == '0) |=> depth_q == '0);
endmodule

// File: rtl/rstk_storage.sv
module rstk_storage
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ENT_W = 12
) (
  input  logic             clk,
  input  logic             rst_l,
  input  rstk_op_e         op_i,
  input  logic [ENT_W-1:0] wr_entry_i,
  output logic [ENT_W-1:0] top_o
);
  logic [ENT_W-1:0] slot_q [DEPTH];
  logic [ENT_W-1:0] slot_d [DEPTH];
  logic             slot_en;

  assign slot_en = (op_i != OP_IDLE);

  // slot 0 is the top; a push shifts toward the bottom, a pop toward the top
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENT_W-1:0] from_above;
    logic [ENT_W-1:0] from_below;

    if (g == 0) begin : g_top
      assign from_above = wr_entry_i;
    end else begin : g_mid_above
      assign from_above = slot_q[g-1];
    end

    if (g == DEPTH - 1) begin : g_bottom
      assign from_below = slot_q[g];
    end else begin : g_mid_below
      assign from_below = slot_q[g+1];
    end

    always_comb begin
      case (op_i)
        OP_PUSH: slot_d[g] = from_above;
        OP_POP:  slot_d[g] = from_below;
        default: slot_d[g] = slot_q[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= slot_d[g];
    end
  end

  assign top_o = slot_q[0];

  // R2: the pushed entry is the next top
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_l)
    (op_i == OP_PUSH) |=> top_o == $past(wr_entry_i));

  // R3: a pop right after a push brings back the earlier top
  p_lifo_r3: assert property (@(posedge clk) disable iff (!rst_l)
    ($past(op_i) == OP_PUSH && op_i == OP_POP) |=> top_o == $past(top_o, 2));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = RSTK_DEPTH,
  parameter int unsigned PC_W  = RSTK_PC_W,
  localparam int unsigned ENT_W = PC_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             push_irq_i,
  input  logic             pop_i,
  input  logic             ret_irq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             cy_i,
  output logic [PC_W-1:0]  ret_pc_o,
  output logic             ret_cy_o,
  output logic             cy_restore_o,
  output logic [CNT_W-1:0] depth_o
);
  logic             rst_meta;
  logic             rst_l;
  rstk_op_e         op;
  logic [ENT_W-1:0] wr_entry;
  logic [ENT_W-1:0] top_entry;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_l    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_l    <= rst_meta;
    end
  end

  rstk_op_decode u_decode (
    .clk          (clk),
    .rst_l        (rst_l),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .ret_irq_i    (ret_irq_i),
    .op_o         (op),
    .cy_restore_o (cy_restore_o)
  );

  rstk_entry_fmt #(.PC_W(PC_W)) u_fmt (
    .pc_i       (pc_i),
    .cy_i       (cy_i),
    .push_irq_i (push_irq_i),
    .entry_o    (wr_entry)
  );

  rstk_depth #(.DEPTH(DEPTH)) u_depth (
    .clk     (clk),
    .rst_l   (rst_l),
    .op_i    (op),
    .depth_o (depth_o)
  );

  rstk_storage #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk        (clk),
    .rst_l      (rst_l),
    .op_i       (op),
    .wr_entry_i (wr_entry),
    .top_o      (top_entry)
  );

  assign ret_cy_o = top_entry[ENT_W-1];
  assign ret_pc_o = top_entry[PC_W-1:0];

  // R2 and R9: a call saves the following address, wrapping within the field
  p_call_next_r9: assert property (@(posedge clk) disable iff (!rst_l)
    (push_i && !push_irq_i) |=> ret_pc_o == PC_W'($past(pc_i) + 1'b1));

  // R2: an interrupt entry saves the current address and carry
  p_irq_save_r2: assert property (@(posedge clk) disable iff (!rst_l)
    (push_i && push_irq_i) |=> (ret_pc_o == $past(pc_i)) && (ret_cy_o == $past(cy_i)));

  // R6: a pop at empty leaves the presented entry unchanged
  p_empty_top_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (pop_i && !push_i && depth_o == '0) |=> $stable(ret_pc_o) && $stable(ret_cy_o));
endmodule

// File: tb/ret_stack_tb.sv
`timescale 1ns/1ps
module ret_stack_tb;
  logic        clk;
  logic        rst_n;
  logic        push_i, push_irq_i, pop_i, ret_irq_i, cy_i;
  logic [10:0] pc_i;
  logic [10:0] ret_pc_o;
  logic        ret_cy_o, cy_restore_o;
  logic [2:0]  depth_o;

  int n_vec;
  int n_bad;
  bit done;

  ret_stack u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_irq_i(push_irq_i),
    .pop_i(pop_i), .ret_irq_i(ret_irq_i), .pc_i(pc_i), .cy_i(cy_i),
    .ret_pc_o(ret_pc_o), .ret_cy_o(ret_cy_o), .cy_restore_o(cy_restore_o),
    .depth_o(depth_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        psh;
    logic        pirq;
    logic        pop;
    logic        rirq;
    logic [10:0] pc;
    logic        cy;
    logic [10:0] epc;
    logic        ecy;
    logic        erst;
    logic [2:0]  edep;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,11'h100,1'b1, 11'h000,1'b0,1'b0,3'd1}, // R2 call
    '{1'b1,1'b1,1'b0,1'b0,11'h222,1'b0, 11'h101,1'b1,1'b0,3'd2}, // R2 irq
    '{1'b0,1'b0,1'b1,1'b1,11'h000,1'b0, 11'h222,1'b0,1'b1,3'd1}, // R3 R5
    '{1'b0,1'b0,1'b1,1'b0,11'h000,1'b0, 11'h101,1'b1,1'b0,3'd0}, // R3 R5
    '{1'b0,1'b0,1'b1,1'b1,11'h000,1'b0, 11'h000,1'b0,1'b1,3'd0}, // R6
    '{1'b1,1'b0,1'b0,1'b0,11'h7FF,1'b1, 11'h000,1'b0,1'b0,3'd1}, // R9
    '{1'b1,1'b1,1'b0,1'b0,11'h011,1'b0, 11'h000,1'b1,1'b0,3'd2}, // R9
    '{1'b1,1'b0,1'b0,1'b0,11'h033,1'b1, 11'h011,1'b0,1'b0,3'd3}, // R8
    '{1'b1,1'b1,1'b0,1'b0,11'h055,1'b1, 11'h034,1'b1,1'b0,3'd4}, // R8
    '{1'b1,1'b0,1'b0,1'b0,11'h0AA,1'b0, 11'h055,1'b1,1'b0,3'd4}, // R4
    '{1'b1,1'b1,1'b1,1'b1,11'h3C0,1'b1, 11'h0AB,1'b0,1'b0,3'd4}, // R7 R4
    '{1'b0,1'b0,1'b1,1'b1,11'h000,1'b0, 11'h3C0,1'b1,1'b1,3'd3}, // R3
    '{1'b0,1'b0,1'b1,1'b0,11'h000,1'b0, 11'h0AB,1'b0,1'b0,3'd2}, // R3
    '{1'b0,1'b0,1'b1,1'b1,11'h000,1'b0, 11'h055,1'b1,1'b1,3'd1}, // R3
    '{1'b0,1'b0,1'b1,1'b1,11'h000,1'b0, 11'h034,1'b1,1'b1,3'd0}, // R4 oldest lost
    '{1'b0,1'b0,1'b1,1'b0,11'h000,1'b0, 11'h034,1'b1,1'b0,3'd0}, // R6 bottom slot
    '{1'b0,1'b0,1'b0,1'b1,11'h000,1'b0, 11'h034,1'b1,1'b0,3'd0}  // R5 idle
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_i = 1'b0; push_irq_i = 1'b0; pop_i = 1'b0;
    ret_irq_i = 1'b0; pc_i = '0; cy_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 depth in reset", int'(depth_o), 0);
    chk("R1 pc in reset", int'(ret_pc_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 depth after release", int'(depth_o), 0);
    chk("R1 pc after release", int'(ret_pc_o), 0);
    chk("R1 cy after release", int'(ret_cy_o), 0);
    chk("R1 restore after release", int'(cy_restore_o), 0);

    for (int i = 0; i < NV; i++) begin
      push_i = VEC[i].psh; push_irq_i = VEC[i].pirq;
      pop_i = VEC[i].pop; ret_irq_i = VEC[i].rirq;
      pc_i = VEC[i].pc; cy_i = VEC[i].cy;
      #1;
      chk($sformatf("R2/R3 top pc vec %0d", i), int'(ret_pc_o), int'(VEC[i].epc));
      chk($sformatf("R2/R3 top cy vec %0d", i), int'(ret_cy_o), int'(VEC[i].ecy));
      chk($sformatf("R5/R7 restore vec %0d", i), int'(cy_restore_o), int'(VEC[i].erst));
      @(negedge clk);
      chk($sformatf("R8/R4 depth vec %0d", i), int'(depth_o), int'(VEC[i].edep));
    end
    idle_inputs();

    // R1: reset asserted while entries are held clears everything at once
    push_i = 1'b1; pc_i = 11'h123; cy_i = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R2 pc before mid reset", int'(ret_pc_o), 'h124);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset depth", int'(depth_o), 0);
    chk("R1 mid reset pc", int'(ret_pc_o), 0);
    chk("R1 mid reset cy", int'(ret_cy_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: an empty pop right after reset presents zero and keeps the count
    pop_i = 1'b1; ret_irq_i = 1'b1;
    #1;
    chk("R6 empty pop pc", int'(ret_pc_o), 0);
    chk("R5 empty pop restore", int'(cy_restore_o), 1);
    @(negedge clk);
    idle_inputs();
    chk("R6 empty pop depth", int'(depth_o), 0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule